// File: doc/BRIEF.md
# Dual-Path Divider Configuration Register

This block keeps the feedback (M) and output (N) divide values of a frequency synthesizer, together with a 3-bit test-select code. The values arrive by one of two paths. The parallel path has a 9-bit M word, a 2-bit N word and a level/edge control called `par_load`. While `par_load` is low, the registers follow the parallel words. When it rises, they capture those words and then hold them.

The serial path has its own clock (`ser_clk`), a data line and a transfer strobe (`ser_xfer`). A 14-bit stream is shifted in. It carries the test code first, then N, then M, and each field is sent most significant bit first. The shifted word is copied into the active registers when `ser_xfer` falls. That falling edge is seen through a two-flop synchronizer in the block clock domain.

Serial operation requires `par_load` to be high. The test code can only be set serially, and it is held at zero whenever `par_load` is low. The last shift stage is brought out so that it can be routed to a test pin.

Top module: `divcfg_loader`

## Requirements
- R1: While `rst_n` is low, `m_out`, `n_out`, `t_out` and `shift_out` are all zero.
- R2: When `par_load` is low at a rising `clk` edge, `m_out`/`n_out` take `m_par`/`n_par` at that edge, and `t_out` becomes 000.
- R3: At the first `clk` edge where `par_load` is seen high after being low, `m_out`/`n_out` capture `m_par`/`n_par`. Later changes of `m_par`/`n_par` have no effect while `par_load` stays high.
- R4: While `par_load` is high, each rising `ser_clk` edge shifts `ser_data` into the LSB of a 14-bit word. `shift_out` is the word's MSB, which after 14 shifts is the first bit sent.
- R5: Rising `ser_clk` edges while `par_load` is low leave the shift word unchanged.
- R6: Stream field order, first bit to last: T[2] T[1] T[0], N[1] N[0], M[8] down to M[0].
- R7: A falling edge of `ser_xfer` while `par_load` is high loads M, N and T from the shift word at the third rising `clk` edge after the fall. A rising edge of `ser_xfer` has no effect.
- R8: A falling edge of `ser_xfer` that is detected while `par_load` is low is ignored. The outputs keep following the parallel words, with `t_out` = 000.
- R9: When a serial transfer and the parallel rising-edge capture fall on the same `clk` edge, the serial values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load | input | 1 | Parallel transparency/capture control, also serial enable |
| m_par | input | 9 | Parallel M word |
| n_par | input | 2 | Parallel N word |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data bit |
| ser_xfer | input | 1 | Serial transfer strobe, acts on its falling edge |
| m_out | output | 9 | Active M divide value |
| n_out | output | 2 | Active N divide value |
| t_out | output | 3 | Active test-select code |
| shift_out | output | 1 | Last stage of the serial shift word |

## Verification
Two events can land on the same `clk` edge: the synchronized `ser_xfer` fall and the first edge at which `par_load` is seen high. The bench provokes this by dropping the strobe at one falling clock edge and raising `par_load` exactly two falling edges later. The detected transfer and the parallel rising capture then share one rising edge. The result is judged by requiring the outputs to hold the shifted frame rather than the parallel words, which are set to a distinctly different value.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int unsigned DEF_M_W   = 9;
  localparam int unsigned DEF_N_W   = 2;
  localparam int unsigned DEF_T_W   = 3;
  localparam int unsigned DEF_SYNC  = 2;
endpackage

// File: rtl/divcfg_shifter.sv
module divcfg_shifter #(
  parameter int unsigned W = 14
) (
  input  logic         sclk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)   word <= '0;
    else if (en)  word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/divcfg_fall_sync.sv
module divcfg_fall_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], din};
  end
  assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/divcfg_regs.sv
module divcfg_regs #(
  parameter int unsigned M_W = 9,
  parameter int unsigned N_W = 2,
  parameter int unsigned T_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pload,
  input  logic           xfer,
  input  logic [M_W-1:0] m_par,
  input  logic [N_W-1:0] n_par,
  input  logic [M_W-1:0] m_ser,
  input  logic [N_W-1:0] n_ser,
  input  logic [T_W-1:0] t_ser,
  output logic           pload_q,
  output logic [M_W-1:0] m_q,
  output logic [N_W-1:0] n_q,
  output logic [T_W-1:0] t_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pload_q <= 1'b0;
      m_q     <= '0;
      n_q     <= '0;
      t_q     <= '0;
    end else begin
      pload_q <= pload;
      if (!pload) begin
        m_q <= m_par;
        n_q <= n_par;
        t_q <= '0;
      end else if (xfer) begin
        m_q <= m_ser;
        n_q <= n_ser;
        t_q <= t_ser;
      end else if (!pload_q) begin
        m_q <= m_par;
        n_q <= n_par;
      end
    end
  end
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
#(
  parameter int unsigned M_W   = DEF_M_W,
  parameter int unsigned N_W   = DEF_N_W,
  parameter int unsigned T_W   = DEF_T_W,
  parameter int unsigned SYNC  = DEF_SYNC
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load,
  input  logic [M_W-1:0] m_par,
  input  logic [N_W-1:0] n_par,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_xfer,
  output logic [M_W-1:0] m_out,
  output logic [N_W-1:0] n_out,
  output logic [T_W-1:0] t_out,
  output logic           shift_out
);
  localparam int unsigned FW = T_W + N_W + M_W;

  function automatic logic [T_W-1:0] fld_t(input logic [FW-1:0] w);
    return w[FW-1 -: T_W];
  endfunction
  function automatic logic [N_W-1:0] fld_n(input logic [FW-1:0] w);
    return w[M_W +: N_W];
  endfunction
  function automatic logic [M_W-1:0] fld_m(input logic [FW-1:0] w);
    return w[M_W-1:0];
  endfunction

  logic [FW-1:0]  frame;
  logic           xfer_evt;
  logic           pload_q;
  logic [M_W-1:0] frame_m;
  logic [N_W-1:0] frame_n;
  logic [T_W-1:0] frame_t;

  divcfg_shifter #(.W(FW)) u_shift (
    .sclk (ser_clk),
    .rst_n(rst_n),
    .en   (par_load),
    .din  (ser_data),
    .word (frame)
  );

  divcfg_fall_sync #(.STAGES(SYNC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ser_xfer),
    .fall (xfer_evt)
  );

  assign frame_m = fld_m(frame);
  assign frame_n = fld_n(frame);
  assign frame_t = fld_t(frame);

  divcfg_regs #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .pload  (par_load),
    .xfer   (xfer_evt),
    .m_par  (m_par),
    .n_par  (n_par),
    .m_ser  (frame_m),
    .n_ser  (frame_n),
    .t_ser  (frame_t),
    .pload_q(pload_q),
    .m_q    (m_out),
    .n_q    (n_out),
    .t_q    (t_out)
  );

  assign shift_out = frame[FW-1];
endmodule

// File: rtl/divcfg_loader_chk.sv
module divcfg_loader_chk #(
  parameter int unsigned M_W = 9,
  parameter int unsigned N_W = 2,
  parameter int unsigned T_W = 3,
  parameter int unsigned FW  = 14
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ser_clk,
  input logic           par_load,
  input logic           ser_data,
  input logic [M_W-1:0] m_par,
  input logic [N_W-1:0] n_par,
  input logic [M_W-1:0] m_out,
  input logic [N_W-1:0] n_out,
  input logic [T_W-1:0] t_out,
  input logic [FW-1:0]  frame,
  input logic           pload_q,
  input logic           xfer_evt
);
  a_r2_follow_parallel: assert property (@(posedge clk) disable iff (!rst_n)
    !par_load |=> (m_out == $past(m_par)) && (n_out == $past(n_par)));

  a_r8_test_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    !par_load |=> (t_out == '0));

  a_r3_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (par_load && pload_q && !xfer_evt) |=>
      (m_out == $past(m_out)) && (n_out == $past(n_out)) && (t_out == $past(t_out)));

  a_r9_serial_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (par_load && xfer_evt) |=> (t_out == $past(frame[FW-1 -: T_W])) &&
      (m_out == $past(frame[M_W-1:0])));

  a_r4_shift_in: assert property (@(posedge ser_clk) disable iff (!rst_n)
    par_load |=> frame[0] == $past(ser_data));

  a_r5_frozen_low: assert property (@(posedge ser_clk) disable iff (!rst_n)
    !par_load |=> frame == $past(frame));
endmodule

bind divcfg_loader divcfg_loader_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W), .FW(FW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ser_clk (ser_clk),
  .par_load(par_load),
  .ser_data(ser_data),
  .m_par   (m_par),
  .n_par   (n_par),
  .m_out   (m_out),
  .n_out   (n_out),
  .t_out   (t_out),
  .frame   (frame),
  .pload_q (pload_q),
  .xfer_evt(xfer_evt)
);

// File: tb/tb_divcfg_loader.sv
module tb_divcfg_loader;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       par_load = 1'b1;
  logic [8:0] m_par = '0;
  logic [1:0] n_par = '0;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic       ser_xfer = 1'b1;
  logic [8:0] m_out;
  logic [1:0] n_out;
  logic [2:0] t_out;
  logic       shift_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [8:0] m;
    logic [1:0] n;
    logic [2:0] t;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  event chk_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  divcfg_loader dut (
    .clk(clk), .rst_n(rst_n), .par_load(par_load), .m_par(m_par), .n_par(n_par),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_xfer(ser_xfer),
    .m_out(m_out), .n_out(n_out), .t_out(t_out), .shift_out(shift_out)
  );

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (m_out !== e.m || n_out !== e.n || t_out !== e.t) begin
          fails++;
          $display("FAIL %s: got m=%h n=%h t=%b expected m=%h n=%h t=%b",
                   e.tag, m_out, n_out, t_out, e.m, e.n, e.t);
        end
      end
    end
  end

  task automatic expect_cfg(input logic [8:0] m, input logic [1:0] n,
                            input logic [2:0] t, input string tag);
    exp_t e;
    e.m = m; e.n = n; e.t = t; e.tag = tag;
    sb_q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // frame built from fields: T first, then N, then M, each MSB first (R6)
  task automatic send_frame(input logic [2:0] t, input logic [1:0] n, input logic [8:0] m);
    logic [13:0] w;
    w = {t, n, m};
    for (int i = 13; i >= 0; i--) begin
      ser_data = w[i];
      #3 ser_clk = 1'b1;
      #3 ser_clk = 1'b0;
    end
    #2;
  endtask

  task automatic xfer_pulse();
    @(negedge clk);
    ser_xfer = 1'b0;
    clocks(5);
    ser_xfer = 1'b1;
    clocks(3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clocks(3);
    // R1: reset state
    expect_cfg(9'h000, 2'd0, 3'b000, "R1 reset");
    check_bit(shift_out, 1'b0, "R1 shift_out reset");
    rst_n = 1'b1;
    clocks(2);

    // R2: transparency while par_load low, two patterns
    par_load = 1'b0; m_par = 9'h1A5; n_par = 2'd2;
    clocks(2);
    expect_cfg(9'h1A5, 2'd2, 3'b000, "R2 follow a");
    m_par = 9'h0F3; n_par = 2'd1;
    clocks(2);
    expect_cfg(9'h0F3, 2'd1, 3'b000, "R2 follow b");

    // R3: rising capture, then hold
    m_par = 9'h155; n_par = 2'd3;
    par_load = 1'b1;
    clocks(2);
    expect_cfg(9'h155, 2'd3, 3'b000, "R3 capture");
    m_par = 9'h0AA; n_par = 2'd0;
    clocks(3);
    expect_cfg(9'h155, 2'd3, 3'b000, "R3 hold");

    // R4, R6, R7: serial frame and transfer
    send_frame(3'b101, 2'b10, 9'h1C3);
    check_bit(shift_out, 1'b1, "R4 shift_out is T2");
    expect_cfg(9'h155, 2'd3, 3'b000, "R7 no change before strobe");
    @(negedge clk);
    ser_xfer = 1'b0;
    clocks(2);
    expect_cfg(9'h155, 2'd3, 3'b000, "R7 not yet after two edges");
    clocks(1);
    expect_cfg(9'h1C3, 2'd2, 3'b101, "R7 R6 loaded at third edge");
    ser_xfer = 1'b1;
    clocks(4);
    expect_cfg(9'h1C3, 2'd2, 3'b101, "R7 rising strobe no effect");

    // R6: second pattern, M8 leads M field
    send_frame(3'b011, 2'b00, 9'h100);
    check_bit(shift_out, 1'b0, "R4 shift_out second frame");
    xfer_pulse();
    expect_cfg(9'h100, 2'd0, 3'b011, "R6 field order b");

    // R8: par_load low forces T to zero, follows parallel
    m_par = 9'h03C; n_par = 2'd1;
    par_load = 1'b0;
    clocks(2);
    expect_cfg(9'h03C, 2'd1, 3'b000, "R8 test forced zero");

    // R5: shifting ignored while low
    send_frame(3'b111, 2'b11, 9'h1FF);
    check_bit(shift_out, 1'b0, "R5 shift_out unchanged");
    // R8: transfer ignored while low
    xfer_pulse();
    expect_cfg(9'h03C, 2'd1, 3'b000, "R8 transfer ignored low");
    par_load = 1'b1;
    clocks(2);
    xfer_pulse();
    expect_cfg(9'h100, 2'd0, 3'b011, "R5 old frame kept");

    // R9: serial transfer and parallel capture on same edge
    send_frame(3'b110, 2'b01, 9'h07E);
    @(negedge clk);
    par_load = 1'b0; m_par = 9'h111; n_par = 2'd3;
    clocks(2);
    ser_xfer = 1'b0;
    clocks(2);
    par_load = 1'b1;
    clocks(3);
    expect_cfg(9'h07E, 2'd1, 3'b110, "R9 serial wins");
    ser_xfer = 1'b1;
    clocks(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule